// File: doc/BRIEF.md
# Scan Chain with Held Parallel Outputs

This block is a chain of scan flip-flops whose parallel outputs pass through a hold stage. In functional mode each stage captures its parallel data bit on the clock edge. In shift mode the stages form a serial path from the serial input to the serial output. The serial path always runs from the internal flip-flop state of each stage. It never passes through the hold stage.

When the hold control is high, the parallel outputs keep the values they had before hold was raised. The chain underneath can still capture or shift any number of times. During a scan load this keeps the logic downstream quiet and isolated. It also lowers switching activity. When hold falls, the outputs pick up the internal state on the same clock edge.

Top module: `scan_hold_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every internal stage and every held output, so after that edge `q` is all zeros and `so` is 0.
- R2: With `tc` low and `hold` low, a rising edge loads `d` into the stages, and `q` equals that `d` right after the edge.
- R3: With `tc` high, a rising edge shifts the chain toward higher indices. Stage 0 takes `si` and stage i takes the old value of stage i-1. With `hold` low, `q` shows the shifted word after the edge.
- R4: `so` always carries the internal state of the last stage, N-1. This holds whether `hold` is high or low.
- R5: While `hold` is high at a rising edge, `q` does not change. This is true for any value of `tc`, `si` and `d`, and for any number of such edges.
- R6: While `hold` is high, shifting and capturing still update the internal stages. Shifted-in bits therefore reach `so` after N edges, and a captured word shows up on `so` at once.
- R7: On the first rising edge with `hold` low after a held period, `q` takes the internal state as updated by that same edge.
- R8: Reset takes priority over `hold`: a reset edge while `hold` is high still clears `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock, rising edge active |
| rst  | input  | 1 | Synchronous reset, active high |
| tc   | input  | 1 | 1 = shift from serial path, 0 = capture `d` |
| hold | input  | 1 | 1 = freeze parallel outputs |
| si   | input  | 1 | Serial input into stage 0 |
| d    | input  | N | Parallel functional data |
| q    | output | N | Held parallel outputs |
| so   | output | 1 | Serial output, internal state of stage N-1 |

## Verification
If the internal state is wrong, `so` shows it within N shift edges, even while `hold` masks `q`. If the hold stage is wrong, `q` moves during a held scan on the very first edge. If the release path is wrong, `q` lags by one edge after `hold` falls. The bench steps through a held scan of many bits. On every edge it compares `so` against a serial model and checks that `q` stays frozen.

// File: rtl/scan_hold_chain.sv
module scan_hold_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tc,
  input  logic         hold,
  input  logic         si,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         so
);

  logic [N-1:0] st;
  logic [N-1:0] st_nxt;
  logic [N-1:0] q_r;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic sd;
    if (i == 0) begin : g_head
      assign sd = si;
    end else begin : g_link
      assign sd = st[i-1];
    end
    assign st_nxt[i] = tc ? sd : d[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= '0;
      q_r <= '0;
    end else begin
      st <= st_nxt;
      if (!hold) q_r <= st_nxt;
    end
  end

  assign q  = q_r;
  assign so = st[N-1];

endmodule

// File: rtl/scan_hold_chain_chk.sv
module scan_hold_chain_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tc,
  input logic         hold,
  input logic         si,
  input logic [N-1:0] d,
  input logic [N-1:0] q,
  input logic         so,
  input logic [N-1:0] st
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q == '0 && so == 1'b0));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!tc && !hold) |=> q == $past(d));

  p_shift_r3: assert property (@(posedge clk) disable iff (rst)
    tc |=> st == {$past(st[N-2:0]), $past(si)});

  p_serial_tap_r4: assert property (@(posedge clk) disable iff (rst)
    tc |=> so == $past(st[N-2]));

  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    !hold |=> q == st);

endmodule

bind scan_hold_chain scan_hold_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .tc(tc), .hold(hold), .si(si),
  .d(d), .q(q), .so(so), .st(st)
);

// File: tb/tb_scan_hold_chain.sv
module tb_scan_hold_chain;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tc = 1'b0;
  logic hold = 1'b0;
  logic si = 1'b0;
  logic [N-1:0] d = '0;
  logic [N-1:0] q;
  logic so;

  int applied = 0;
  int bad = 0;
  logic [N-1:0] m_st;

  // row: {rst, tc, hold, si, d[7:0], exp_q[7:0], exp_so}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R1
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b1}, // R2
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}, // R2
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h79, 1'b0}, // R3
    {1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hF2, 1'b1}, // R3 d ignored
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hF2, 1'b1}, // R5
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hF2, 1'b1}, // R5
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF2, 1'b1}, // R6
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF2, 1'b0}, // R6 R4
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'hF2, 1'b1}, // R6 capture under hold
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h03, 1'b0}, // R7
    {1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h03, 1'b1}, // R5
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0}, // R8
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h5A, 1'b0}  // R2
  };

  scan_hold_chain #(.N(N)) dut (
    .clk(clk), .rst(rst), .tc(tc), .hold(hold), .si(si),
    .d(d), .q(q), .so(so)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] eq, input logic eso);
    applied++;
    if (q !== eq || so !== eso) begin
      bad++;
      $display("FAIL %s: q=%h so=%b expected q=%h so=%b", req, q, so, eq, eso);
    end
  endtask

  task automatic step(input logic r, input logic t, input logic h,
                      input logic s, input logic [N-1:0] dv);
    @(negedge clk);
    rst = r; tc = t; hold = h; si = s; d = dv;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: q=%h so=%b expected run to finish", q, so);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      check($sformatf("R%0d table row %0d", 1, i), VEC[i][8:1], VEC[i][0]);
    end

    // long held scan: q frozen (R5), so tracks serial model (R4, R6)
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
    m_st = 8'hC3;
    check("R2 preload", 8'hC3, 1'b1);
    for (int k = 0; k < 100; k++) begin
      logic b;
      b = ((k * 7) % 5) < 2;
      m_st = {m_st[N-2:0], b};
      step(1'b0, 1'b1, 1'b1, b, logic'(k) ? 8'hFF : 8'h00);
      check("R5 R6 held shift", 8'hC3, m_st[N-1]);
    end
    // release on a shift edge: q shows updated state (R7)
    m_st = {m_st[N-2:0], 1'b1};
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    check("R7 release", m_st, m_st[N-1]);

    // shift a word out through so with hold low (R3, R4)
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'b1011_0010);
    m_st = 8'b1011_0010;
    check("R2 load", m_st, 1'b1);
    for (int k = 0; k < N; k++) begin
      m_st = {m_st[N-2:0], 1'b0};
      step(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
      check("R3 R4 unload", m_st, m_st[N-1]);
    end

    // reset while held and shifting (R8, R1)
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    check("R2 all ones", 8'hFF, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'hFF);
    check("R8 reset under hold", 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R1 internal cleared", 8'h00, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule